// File: doc/BRIEF.md
# Password-guarded pin lock register

This block keeps one lock bit for each pin of a GPIO-style pin array. The pins are grouped into banks of 32, with one 32-bit lock word per bank and up to eight banks. The whole lock vector is driven out continuously, so that neighbouring pin control logic can refuse configuration writes to any pin whose bit is set. Software reaches the block over a simple register bus with address, write data, a write strobe, a read strobe and read data.

A lock word cannot be changed by a single write. Software must first store a fixed key value into a separate key register. That write arms the block, and the write that follows it may replace one lock word. Any other write cancels the arming. A lock-word write that arrives without arming is dropped, and it sets a sticky flag that software can read and clear. Lock words can be read back, so software can set or clear a single bit with a read-modify-write.

Top module: `pin_lock_guard`

## Requirements
- R1: After reset every lock word is all ones (every pin locked), the block is disarmed and the violation flag reads 0.
- R2: A write of 0x00A5A501 to the key register at offset 0x520 arms the block for exactly one following bus write.
- R3: A write to offset 0x500 + 4*n (n below the bank count) while armed replaces lock word n with the write data; bit k of word n drives `pin_lock[32*n + k]`. All ones locks the whole bank and all zeros unlocks it.
- R4: Every write other than a correct key write disarms the block, including a wrong key value, a write to any other offset and the lock-word write that uses up the arming. Reads never change the arming.
- R5: A lock-word write made while disarmed leaves every lock word unchanged.
- R6: A lock-word write made while disarmed sets a sticky violation flag, read as bit 0 of offset 0x524. Writing 0x524 with bit 0 set clears it; writing it with bit 0 clear leaves it.
- R7: `bus_rdata` carries the addressed register one cycle after `bus_rd` is sampled high and is zero in every other cycle; lock words read back their current value.
- R8: Reading the key register, or any offset that maps to no register, returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, one cycle after the read strobe |
| pin_lock | output | NUM_BANKS*DATA_W (256) | Lock bit per pin, bank n in bits 32n+31..32n |

## Verification
The assertions assume that the bus is word aligned in use and that a write and a read may share a cycle, with the read returning the state from before the write. They also assume that reset is held for at least one clock edge, so the first edge after its release sees the reset values. The stimulus issues exactly one strobe per access, keeps all offsets multiples of four, and spaces each access with an idle cycle. This keeps every arming decision tied to a single, well-defined preceding write.

// File: rtl/pin_lock_pkg.sv
package pin_lock_pkg;

  localparam logic [31:0] LK_BASE_OFS = 32'h0000_0500;
  localparam logic [31:0] LK_KEY_OFS  = 32'h0000_0520;
  localparam logic [31:0] LK_FLAG_OFS = 32'h0000_0524;
  localparam logic [31:0] LK_KEY_VAL  = 32'h00A5_A501;
  localparam int          LK_MAX_BANKS = 8;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_WORD = 2'd1,
    RD_FLAG = 2'd2
  } rd_kind_e;

  // Byte offset of the lock word for bank idx.
  function automatic logic [31:0] word_offset(input int idx);
    return LK_BASE_OFS + (32'(idx) << 2);
  endfunction

  // True when a written value is the arming key.
  function automatic logic key_ok(input logic [31:0] value);
    return value == LK_KEY_VAL;
  endfunction

endpackage

// File: rtl/pin_lock_decode.sv
module pin_lock_decode
  import pin_lock_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 wr,
  input  logic                 rd,
  output logic                 key_hit_ok,
  output logic                 any_wr,
  output logic                 flag_clr,
  output logic [NUM_BANKS-1:0] word_wr,
  output logic [NUM_BANKS-1:0] word_rd,
  output rd_kind_e             rd_kind
);

  logic [31:0]          addr32;
  logic [NUM_BANKS-1:0] word_hit;
  logic                 key_hit;
  logic                 flag_hit;

  assign addr32 = 32'(addr);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign word_hit[b] = (addr32 == word_offset(b));
  end

  assign key_hit  = (addr32 == LK_KEY_OFS);
  assign flag_hit = (addr32 == LK_FLAG_OFS);

  assign any_wr     = wr;
  assign key_hit_ok = wr && key_hit && key_ok(32'(wdata));
  assign flag_clr   = wr && flag_hit && wdata[0];
  assign word_wr    = wr ? word_hit : '0;
  assign word_rd    = rd ? word_hit : '0;

  always_comb begin
    rd_kind = RD_ZERO;
    if (rd) begin
      if (|word_hit)     rd_kind = RD_WORD;
      else if (flag_hit) rd_kind = RD_FLAG;
    end
  end

endmodule

// File: rtl/pin_lock_arm.sv
module pin_lock_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic any_wr,
  input  logic key_hit_ok,
  input  logic word_req,
  input  logic flag_clr,
  output logic armed,
  output logic flag,
  output logic word_grant,
  output logic flag_set
);

  logic armed_q;
  logic flag_q;

  assign word_grant = word_req && armed_q;
  assign flag_set   = word_req && !armed_q;

  // Any write re-decides the arming: only a correct key leaves it set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (any_wr) armed_q <= key_hit_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (flag_set) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign armed = armed_q;
  assign flag  = flag_q;

endmodule

// File: rtl/pin_lock_word.sv
module pin_lock_word #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '1;
    else if (upd) q <= din;
  end

endmodule

// File: rtl/pin_lock_rdmux.sv
module pin_lock_rdmux
  import pin_lock_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int DATA_W    = 32
) (
  input  rd_kind_e                      rd_kind,
  input  logic [NUM_BANKS-1:0]          word_rd,
  input  logic [NUM_BANKS*DATA_W-1:0]   words,
  input  logic                          flag,
  output logic [DATA_W-1:0]             data
);

  logic [DATA_W-1:0] word_or;

  always_comb begin
    word_or = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (word_rd[b]) word_or = word_or | words[b*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    unique case (rd_kind)
      RD_WORD: data = word_or;
      RD_FLAG: data = DATA_W'(flag);
      default: data = '0;
    endcase
  end

endmodule

// File: rtl/pin_lock_guard.sv
module pin_lock_guard
  import pin_lock_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic [NUM_BANKS*DATA_W-1:0] pin_lock
);

  localparam int LOCK_W = NUM_BANKS * DATA_W;

  // Named internal events, used by the bound checker.
  logic                 key_hit_ok;
  logic                 any_wr;
  logic                 flag_clr;
  logic [NUM_BANKS-1:0] word_wr;
  logic [NUM_BANKS-1:0] word_rd;
  rd_kind_e             rd_kind;
  logic                 word_req;
  logic                 word_grant;
  logic                 flag_set;
  logic                 armed;
  logic                 flag;
  logic [NUM_BANKS-1:0] lock_upd;
  logic [LOCK_W-1:0]    words;
  logic [DATA_W-1:0]    rd_next;
  logic [DATA_W-1:0]    rdata_q;

  pin_lock_decode #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_decode (
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .wr         (bus_wr),
    .rd         (bus_rd),
    .key_hit_ok (key_hit_ok),
    .any_wr     (any_wr),
    .flag_clr   (flag_clr),
    .word_wr    (word_wr),
    .word_rd    (word_rd),
    .rd_kind    (rd_kind)
  );

  assign word_req = |word_wr;

  pin_lock_arm u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_wr     (any_wr),
    .key_hit_ok (key_hit_ok),
    .word_req   (word_req),
    .flag_clr   (flag_clr),
    .armed      (armed),
    .flag       (flag),
    .word_grant (word_grant),
    .flag_set   (flag_set)
  );

  assign lock_upd = word_wr & {NUM_BANKS{word_grant}};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pin_lock_word #(
      .WIDTH (DATA_W)
    ) u_word (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (lock_upd[b]),
      .din   (bus_wdata),
      .q     (words[b*DATA_W +: DATA_W])
    );
  end

  pin_lock_rdmux #(
    .NUM_BANKS (NUM_BANKS),
    .DATA_W    (DATA_W)
  ) u_rdmux (
    .rd_kind (rd_kind),
    .word_rd (word_rd),
    .words   (words),
    .flag    (flag),
    .data    (rd_next)
  );

  // Registered read path; zero whenever no read was sampled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
  assign pin_lock  = words;

endmodule

// File: rtl/pin_lock_guard_chk.sv
module pin_lock_guard_chk
  import pin_lock_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic                        bus_wr,
  input logic                        bus_rd,
  input logic [DATA_W-1:0]           bus_rdata,
  input logic [NUM_BANKS*DATA_W-1:0] pin_lock,
  input logic                        armed,
  input logic                        flag,
  input logic                        key_hit_ok,
  input logic                        word_req,
  input logic [NUM_BANKS-1:0]        lock_upd
);

  logic flag_wr_one;
  assign flag_wr_one = bus_wr && (bus_addr == ADDR_W'(LK_FLAG_OFS)) && bus_wdata[0];

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ((&pin_lock) && !armed && !flag));

  assert_key_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit_ok |=> armed);

  assert_single_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_upd));

  assert_other_write_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !key_hit_ok) |=> !armed);

  assert_read_keeps_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr) |=> (armed == $past(armed)));

  assert_change_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_lock) |-> $past(armed && word_req));

  assert_violation_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_req && !armed) |=> flag);

  assert_violation_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_wr_one) |=> flag);

  assert_idle_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd) |=> (bus_rdata == '0));

  assert_key_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(LK_KEY_OFS)) |=> (bus_rdata == '0));

endmodule

bind pin_lock_guard pin_lock_guard_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .pin_lock   (pin_lock),
  .armed      (armed),
  .flag       (flag),
  .key_hit_ok (key_hit_ok),
  .word_req   (word_req),
  .lock_upd   (lock_upd)
);

// File: tb/tb_pin_lock_guard.sv
module tb_pin_lock_guard;

  localparam int CLK_PERIOD = 10;
  localparam int NB  = 8;
  localparam int AW  = 12;
  localparam int DW  = 32;
  localparam logic [AW-1:0] KEY_A  = 12'h520;
  localparam logic [AW-1:0] FLAG_A = 12'h524;
  localparam logic [DW-1:0] KEY    = 32'h00A5A501;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic [NB*DW-1:0] pin_lock;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Independent model of the register state.
  logic [DW-1:0] m_word [NB];
  bit m_armed;
  bit m_flag;

  // Scoreboard queues for reads.
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  logic          rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_lock_guard #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_rdata (bus_rdata), .pin_lock (pin_lock)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit is_word(input logic [AW-1:0] a);
    return a >= 12'h500 && a < 12'h500 + 4*NB && a[1:0] == 2'b00;
  endfunction

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == KEY_A) m_armed = (d == KEY);
    else begin
      if (is_word(a)) begin
        if (m_armed) m_word[(a - 12'h500) >> 2] = d;
        else         m_flag = 1'b1;
      end
      if (a == FLAG_A && d[0]) m_flag = 1'b0;
      m_armed = 1'b0;
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Driver: issue a read and push the expected value for the monitor.
  task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    if (is_word(a)) return m_word[(a - 12'h500) >> 2];
    if (a == FLAG_A) return DW'(m_flag);
    return '0;
  endfunction

  task automatic check_pins(input string req);
    for (int b = 0; b < NB; b++)
      check(pin_lock[b*DW +: DW] === m_word[b], req, $sformatf("pin_lock bank %0d", b),
            pin_lock[b*DW +: DW], m_word[b]);
  endtask

  // Monitor.
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (rd_seen) begin
        if (exp_q.size() == 0) check(1'b0, "R7", "unexpected read result", bus_rdata, '0);
        else begin
          logic [DW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(bus_rdata === e, t, "read data", bus_rdata, e);
        end
      end else begin
        check(bus_rdata === '0, "R7", "idle read data", bus_rdata, '0);
      end
    end
  end

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R7 watchdog: actual running expected finished");
    report();
  end

  initial begin
    for (int b = 0; b < NB; b++) m_word[b] = '1;
    m_armed = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state.
    check_pins("R1");
    bus_read(FLAG_A, 32'h0, "R1");
    bus_read(12'h500, 32'hFFFF_FFFF, "R1");

    // R5 / R6: unarmed lock write is dropped and flags a violation.
    bus_write(12'h500, 32'h0);
    check_pins("R5");
    bus_read(FLAG_A, 32'h1, "R6");
    bus_write(FLAG_A, 32'h0);
    bus_read(FLAG_A, 32'h1, "R6");
    bus_write(FLAG_A, 32'h1);
    bus_read(FLAG_A, 32'h0, "R6");

    // R2 / R3: armed write replaces a word; read back (R7).
    bus_write(KEY_A, KEY);
    bus_write(12'h508, 32'h1234_5678);
    check_pins("R3");
    bus_read(12'h508, model_read(12'h508), "R7");

    // R2: arming covers one write only.
    bus_write(KEY_A, KEY);
    bus_write(12'h50C, 32'h0);
    bus_write(12'h50C, 32'hAAAA_AAAA);
    check_pins("R2");
    bus_read(12'h50C, 32'h0, "R2");
    bus_write(FLAG_A, 32'h1);

    // R4: wrong key does not arm.
    bus_write(KEY_A, 32'h00A5_A500);
    bus_write(12'h504, 32'h0);
    check_pins("R4");
    bus_read(FLAG_A, 32'h1, "R4");
    bus_write(FLAG_A, 32'h1);

    // R4: write elsewhere disarms.
    bus_write(KEY_A, KEY);
    bus_write(12'h004, 32'h5);
    bus_write(12'h504, 32'h0);
    check_pins("R4");

    // R4: reads keep the arming.
    bus_write(KEY_A, KEY);
    bus_read(12'h514, 32'hFFFF_FFFF, "R4");
    bus_write(12'h514, 32'h0F0F_0000);
    check_pins("R4");
    bus_read(12'h514, 32'h0F0F_0000, "R4");

    // R8: key register and unmapped offsets read zero.
    bus_read(KEY_A, 32'h0, "R8");
    bus_read(12'h600, 32'h0, "R8");

    // R3: last bank, unlock all then relock all.
    bus_write(KEY_A, KEY);
    bus_write(12'h51C, 32'h0);
    check_pins("R3");
    bus_write(KEY_A, KEY);
    bus_write(12'h51C, 32'hFFFF_FFFF);
    check_pins("R3");

    // R3: read-modify-write of a single bit, key written twice.
    bus_write(KEY_A, KEY);
    bus_write(KEY_A, KEY);
    bus_write(12'h508, model_read(12'h508) & ~32'h0000_0008);
    check_pins("R3");
    bus_read(12'h508, 32'h1234_5670, "R3");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7", "pending reads", DW'(exp_q.size()), '0);
    report();
  end

endmodule